// File: doc/BRIEF.md
# Ring-Buffer Command Queue Fetcher

This block runs a circular command queue held in local memory. A host places 16-bit command words into a ring that starts at a programmable base address. It then moves a write pointer forward through a small 16-bit register file. While the engine's read pointer trails the write pointer, the engine reads halfwords over a simple memory read port. It presents those halfwords on a valid/ready command stream and steps the read pointer forward. The read pointer wraps at the programmed queue size.

The engine works on groups of up to two halfwords, taken from the read pointer at the moment the group begins. A group made of two zero halfwords is a no-op. It is consumed without reaching the stream. A 16-bit status word merges the engine's idle state with busy flags from three downstream engines. Those engines appear here only as busy inputs.

The state machine has seven states. ST_IDLE waits for the pointers to differ. ST_REQ_A issues the first read and ST_WAIT_A waits for its data. ST_REQ_B and ST_WAIT_B fetch the second halfword of the group. ST_SEND_A and ST_SEND_B offer the words downstream. The transitions are:
- ST_IDLE goes to ST_REQ_A when the pointers differ.
- ST_REQ_A goes to ST_WAIT_A.
- ST_WAIT_A, on read data, goes to ST_SEND_A if the advanced read pointer now equals the write pointer (a lone halfword). Otherwise it goes to ST_REQ_B.
- ST_REQ_B goes to ST_WAIT_B.
- ST_WAIT_B, on read data, goes to ST_IDLE for a zero pair. Otherwise it goes to ST_SEND_A.
- ST_SEND_A, on ready, goes to ST_SEND_B for a pair. For a lone halfword it goes to ST_IDLE.
- ST_SEND_B, on ready, goes to ST_IDLE.

Top module: `cmdq_fetch_engine`

## Requirements
- R1: After reset, both pointers and the control register read 0. With all busy inputs low, the status word reads 0x0007.
- R2: The queue length register holds LEN_W bits and gives a queue size of (len+1)*1024 bytes. The read pointer wraps to 0 when it would reach that size. Pointer values written by the host are ANDed with size-1.
- R3: Each pointer is written as a high half at index 4 (write pointer) or 6 (read pointer), followed by a low half at index 3 or 5. Only the low-half write commits the full value. A write to the high half alone changes neither pointer and starts no fetch.
- R4: While the pointers differ, the engine reads the halfword at base+read pointer and then adds 2 to the read pointer. Bit 0 of every pointer and of the base is forced to 0.
- R5: When the read pointer equals the write pointer, the engine issues no reads and emits no commands.
- R6: Status bits 0 and 1 are both 1 exactly when the engine is in ST_IDLE with equal pointers. Status bit 2 is 1 when, in addition, no busy input is high.
- R7: Status bit 4 equals busy_2d, bit 5 equals busy_3d and bit 8 equals busy_isp. All other status bits read 0.
- R8: The memory port keeps at most one read outstanding. mem_req is a one-cycle pulse, and no new pulse is issued before mem_rvalid returns.
- R9: A command word stays on cmd_data with cmd_valid high, unchanged, until cmd_ready accepts it. Words leave in queue order.
- R10: A group is two halfwords, or one if only one remains. A group of two zero halfwords is dropped. A single remaining halfword is emitted whatever its value.
- R11: The register indices are: base low 0, base high 1 (BASE_HI_W bits), length 2, control 7 (13 bits, bits 12:0 stored and read back), status 8. Pointer halves are read back from their write indices.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | ADDR_W | Byte address of the halfword to read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 16 | Read data |
| cmd_valid | output | 1 | Command word valid |
| cmd_data | output | 16 | Command word |
| cmd_ready | input | 1 | Downstream accepts the command word |
| busy_2d | input | 1 | 2D engine busy |
| busy_3d | input | 1 | 3D engine busy |
| busy_isp | input | 1 | Image engine busy |

## Verification
The bench builds the block with LEN_W=3. This gives 13-bit pointers, so the high pointer halves are fully masked, and a 1 KiB queue (length 0) wraps after 512 halfwords. Several commits therefore drive the read pointer across the wrap boundary within a short run. The default BASE_HI_W=7 lets the base-high masking be seen directly. A two-cycle memory latency and a pseudo-random ready pattern exercise the single outstanding read and the hold of stalled words.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ_A,
        ST_WAIT_A,
        ST_REQ_B,
        ST_WAIT_B,
        ST_SEND_A,
        ST_SEND_B
    } fetch_state_e;

    localparam logic [3:0] RI_BASE_LO = 4'd0;
    localparam logic [3:0] RI_BASE_HI = 4'd1;
    localparam logic [3:0] RI_QLEN    = 4'd2;
    localparam logic [3:0] RI_WP_LO   = 4'd3;
    localparam logic [3:0] RI_WP_HI   = 4'd4;
    localparam logic [3:0] RI_RP_LO   = 4'd5;
    localparam logic [3:0] RI_RP_HI   = 4'd6;
    localparam logic [3:0] RI_CTRL    = 4'd7;
    localparam logic [3:0] RI_STAT    = 4'd8;

endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
    import cmdq_pkg::*;
#(
    parameter int LEN_W     = 7,
    parameter int BASE_HI_W = 7,
    localparam int PTR_W    = LEN_W + 10,
    localparam int BASE_W   = 16 + BASE_HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [3:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    input  logic [PTR_W-1:0]  rptr,
    input  logic              fetch_idle,
    input  logic              busy_2d,
    input  logic              busy_3d,
    input  logic              busy_isp,
    output logic [BASE_W-1:0] base,
    output logic [PTR_W:0]    qsize,
    output logic [PTR_W-1:0]  wptr,
    output logic              rp_load,
    output logic [PTR_W-1:0]  rp_load_val
);

    logic [15:0]          base_lo_q;
    logic [BASE_HI_W-1:0] base_hi_q;
    logic [LEN_W-1:0]     qlen_q;
    logic [15:0]          wp_hi_stage;
    logic [15:0]          rp_hi_stage;
    logic [PTR_W-1:0]     wptr_q;
    logic [12:0]          ctrl_q;
    logic [PTR_W-1:0]     ptr_mask;
    logic [PTR_W-1:0]     wp_commit;
    logic [31:0]          wp_full;
    logic [31:0]          rp_full;
    logic [15:0]          status_w;
    logic                 all_idle;

    assign qsize     = ((PTR_W+1)'(qlen_q) + (PTR_W+1)'(1)) << 10;
    assign ptr_mask  = PTR_W'(qsize - (PTR_W+1)'(1)) & ~PTR_W'(1);
    assign wp_commit = PTR_W'({wp_hi_stage, reg_wdata}) & ptr_mask;
    assign rp_load_val = PTR_W'({rp_hi_stage, reg_wdata}) & ptr_mask;
    assign rp_load   = reg_wen && (reg_addr == RI_RP_LO);
    assign base      = {base_hi_q, base_lo_q};
    assign wptr      = wptr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_lo_q   <= '0;
            base_hi_q   <= '0;
            qlen_q      <= '0;
            wp_hi_stage <= '0;
            rp_hi_stage <= '0;
            wptr_q      <= '0;
            ctrl_q      <= '0;
        end else if (reg_wen) begin
            case (reg_addr)
                RI_BASE_LO: base_lo_q   <= {reg_wdata[15:1], 1'b0};
                RI_BASE_HI: base_hi_q   <= reg_wdata[BASE_HI_W-1:0];
                RI_QLEN:    qlen_q      <= reg_wdata[LEN_W-1:0];
                RI_WP_HI:   wp_hi_stage <= reg_wdata;
                RI_WP_LO:   wptr_q      <= wp_commit;
                RI_RP_HI:   rp_hi_stage <= reg_wdata;
                RI_CTRL:    ctrl_q      <= reg_wdata[12:0];
                default: ;
            endcase
        end
    end

    assign all_idle = fetch_idle && !busy_2d && !busy_3d && !busy_isp;
    assign status_w = {7'd0, busy_isp, 2'b00, busy_3d, busy_2d, 1'b0,
                       all_idle, fetch_idle, fetch_idle};
    assign wp_full  = 32'(wptr_q);
    assign rp_full  = 32'(rptr);

    always_comb begin
        case (reg_addr)
            RI_BASE_LO: reg_rdata = base_lo_q;
            RI_BASE_HI: reg_rdata = 16'(base_hi_q);
            RI_QLEN:    reg_rdata = 16'(qlen_q);
            RI_WP_LO:   reg_rdata = wp_full[15:0];
            RI_WP_HI:   reg_rdata = wp_full[31:16];
            RI_RP_LO:   reg_rdata = rp_full[15:0];
            RI_RP_HI:   reg_rdata = rp_full[31:16];
            RI_CTRL:    reg_rdata = {3'b000, ctrl_q};
            RI_STAT:    reg_rdata = status_w;
            default:    reg_rdata = 16'h0000;
        endcase
    end

    // R3: a high-half write alone never moves the active write pointer
    p_wptr_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen && reg_addr == RI_WP_HI) |=> $stable(wptr_q));

    // R7: busy flags appear in the status word
    p_busy_bits_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_w[4] == busy_2d) && (status_w[5] == busy_3d) && (status_w[8] == busy_isp));

endmodule

// File: rtl/cmdq_fetch_fsm.sv
module cmdq_fetch_fsm
    import cmdq_pkg::*;
#(
    parameter int PTR_W  = 17,
    parameter int BASE_W = 23,
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BASE_W-1:0] base,
    input  logic [PTR_W:0]    qsize,
    input  logic [PTR_W-1:0]  wptr,
    input  logic              rp_load,
    input  logic [PTR_W-1:0]  rp_load_val,
    output logic [PTR_W-1:0]  rptr,
    output logic              fetch_idle,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    output logic              cmd_valid,
    output logic [15:0]       cmd_data,
    input  logic              cmd_ready
);

    fetch_state_e state_q, state_d;
    logic [PTR_W-1:0] rptr_q;
    logic [PTR_W-1:0] rp_next;
    logic [PTR_W:0]   rp_sum;
    logic [15:0]      word_a_q, word_b_q;
    logic             pair_q;

    assign rp_sum  = {1'b0, rptr_q} + (PTR_W+1)'(2);
    assign rp_next = (rp_sum >= qsize) ? '0 : rp_sum[PTR_W-1:0];

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (rptr_q != wptr) state_d = ST_REQ_A;
            ST_REQ_A:  state_d = ST_WAIT_A;
            ST_WAIT_A: if (mem_rvalid) state_d = (rp_next == wptr) ? ST_SEND_A : ST_REQ_B;
            ST_REQ_B:  state_d = ST_WAIT_B;
            ST_WAIT_B: if (mem_rvalid)
                           state_d = (word_a_q == 16'h0000 && mem_rdata == 16'h0000)
                                     ? ST_IDLE : ST_SEND_A;
            ST_SEND_A: if (cmd_ready) state_d = pair_q ? ST_SEND_B : ST_IDLE;
            ST_SEND_B: if (cmd_ready) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rptr_q   <= '0;
            word_a_q <= '0;
            word_b_q <= '0;
            pair_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_WAIT_A && mem_rvalid) begin
                word_a_q <= mem_rdata;
                pair_q   <= 1'b0;
            end
            if (state_q == ST_WAIT_B && mem_rvalid) begin
                word_b_q <= mem_rdata;
                pair_q   <= 1'b1;
            end
            if (rp_load)
                rptr_q <= rp_load_val;
            else if ((state_q == ST_WAIT_A || state_q == ST_WAIT_B) && mem_rvalid)
                rptr_q <= rp_next;
        end
    end

    always_comb begin
        mem_req    = (state_q == ST_REQ_A) || (state_q == ST_REQ_B);
        mem_addr   = ADDR_W'(base) + ADDR_W'(rptr_q);
        cmd_valid  = (state_q == ST_SEND_A) || (state_q == ST_SEND_B);
        cmd_data   = (state_q == ST_SEND_B) ? word_b_q : word_a_q;
        fetch_idle = (state_q == ST_IDLE) && (rptr_q == wptr);
        rptr       = rptr_q;
    end

    // R8: a request is a single-cycle pulse
    p_one_outstanding_r8: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |=> !mem_req);

    // R9: a stalled word holds
    p_hold_word_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_data)));

    // R4: reads land on halfword boundaries
    p_even_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !mem_addr[0]);

    // R6: reported idle means no activity on either port
    p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_idle |-> (!cmd_valid && !mem_req));

endmodule

// File: rtl/cmdq_fetch_engine.sv
module cmdq_fetch_engine #(
    parameter int LEN_W     = 7,
    parameter int BASE_HI_W = 7,
    localparam int PTR_W    = LEN_W + 10,
    localparam int BASE_W   = 16 + BASE_HI_W,
    localparam int ADDR_W   = BASE_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wen,
    input  logic [3:0]        reg_addr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [15:0]       mem_rdata,
    output logic              cmd_valid,
    output logic [15:0]       cmd_data,
    input  logic              cmd_ready,
    input  logic              busy_2d,
    input  logic              busy_3d,
    input  logic              busy_isp
);

    logic [BASE_W-1:0] base;
    logic [PTR_W:0]    qsize;
    logic [PTR_W-1:0]  wptr, rptr, rp_load_val;
    logic              rp_load, fetch_idle;

    cmdq_regs #(.LEN_W(LEN_W), .BASE_HI_W(BASE_HI_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .rptr(rptr), .fetch_idle(fetch_idle),
        .busy_2d(busy_2d), .busy_3d(busy_3d), .busy_isp(busy_isp),
        .base(base), .qsize(qsize), .wptr(wptr),
        .rp_load(rp_load), .rp_load_val(rp_load_val)
    );

    cmdq_fetch_fsm #(.PTR_W(PTR_W), .BASE_W(BASE_W), .ADDR_W(ADDR_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .base(base), .qsize(qsize), .wptr(wptr),
        .rp_load(rp_load), .rp_load_val(rp_load_val),
        .rptr(rptr), .fetch_idle(fetch_idle),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready)
    );

endmodule

// File: tb/tb_cmdq_fetch_engine.sv
module tb_cmdq_fetch_engine;

    localparam int LEN_W  = 3;
    localparam int ADDR_W = 24;
    localparam int BASE_OFF = 16'h0100;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wen = 1'b0;
    logic [3:0] reg_addr = 4'd0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic mem_req;
    logic [ADDR_W-1:0] mem_addr;
    logic mem_rvalid = 1'b0;
    logic [15:0] mem_rdata = 16'd0;
    logic cmd_valid;
    logic [15:0] cmd_data;
    logic cmd_ready = 1'b1;
    logic busy_2d = 1'b0, busy_3d = 1'b0, busy_isp = 1'b0;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit stall_mode = 1'b0;
    logic [7:0] lfsr = 8'hA5;

    logic [15:0] mem [0:4095];
    logic        p1 = 1'b0;
    logic [ADDR_W-1:0] a1 = '0;

    logic [15:0] exp_q[$];
    logic [15:0] stage[$];
    int wp_model = 0;
    int qsize_model = 1024;
    int outstanding = 0;
    int r8_viol = 0;
    int r9_viol = 0;
    logic prev_stall = 1'b0;
    logic [15:0] prev_data = 16'd0;

    cmdq_fetch_engine #(.LEN_W(LEN_W)) dut (
        .clk(clk), .rst_n(rst_n),
        .reg_wen(reg_wen), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_ready(cmd_ready),
        .busy_2d(busy_2d), .busy_3d(busy_3d), .busy_isp(busy_isp)
    );

    always #2 clk = ~clk;

    // memory model: two-cycle read latency
    always @(posedge clk) begin
        p1 <= mem_req;
        a1 <= mem_addr;
        mem_rvalid <= p1;
        mem_rdata <= mem[a1[12:1]];
        lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        cmd_ready <= stall_mode ? lfsr[0] : 1'b1;
        cycles <= cycles + 1;
    end

    // monitor / scoreboard, sampled between edges
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req) begin
                if (outstanding != 0) r8_viol++;
                outstanding = 1;
            end
            if (mem_rvalid) outstanding = 0;
            if (prev_stall && !(cmd_valid && cmd_data == prev_data)) r9_viol++;
            prev_stall = cmd_valid && !cmd_ready;
            prev_data = cmd_data;
            if (cmd_valid && cmd_ready) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL R9/R10: unexpected word actual=%h expected=none", cmd_data);
                end else begin
                    logic [15:0] e;
                    e = exp_q.pop_front();
                    if (e !== cmd_data) begin
                        errors++;
                        $display("FAIL R9: stream word actual=%h expected=%h", cmd_data, e);
                    end
                end
            end
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", cycles);
            finish_run();
        end
    end

    task automatic reg_write(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wen = 1'b0;
    endtask

    task automatic reg_read(input logic [3:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        logic [15:0] s;
        for (int i = 0; i < 5000; i++) begin
            reg_read(4'd8, s);
            if (s[0] && exp_q.size() == 0) break;
        end
    endtask

    // driver: place staged words in the ring, predict the stream, commit pointer
    task automatic commit();
        int n;
        n = stage.size();
        for (int i = 0; i < n; i++) begin
            mem[((BASE_OFF + wp_model) >> 1) & 4095] = stage[i];
            wp_model = (wp_model + 2) % qsize_model;
        end
        for (int i = 0; i < n; i += 2) begin
            if (i + 1 < n) begin
                if (!(stage[i] == 16'h0 && stage[i+1] == 16'h0)) begin
                    exp_q.push_back(stage[i]);
                    exp_q.push_back(stage[i+1]);
                end
            end else begin
                exp_q.push_back(stage[i]);
            end
        end
        stage.delete();
        reg_write(4'd4, 16'h0000);
        reg_write(4'd3, 16'(wp_model));
        wait_idle();
    endtask

    initial begin
        logic [15:0] v;
        for (int i = 0; i < 4096; i++) mem[i] = 16'h0000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(4'd8, v); check("R1 status", v, 16'h0007);
        reg_read(4'd7, v); check("R1 ctrl", v, 16'h0000);
        reg_read(4'd3, v); check("R1 wptr", v, 16'h0000);
        reg_read(4'd5, v); check("R1 rptr", v, 16'h0000);

        // R11 base / control registers
        reg_write(4'd0, 16'h0101); reg_read(4'd0, v); check("R11 base low even", v, 16'h0100);
        reg_write(4'd1, 16'hFFFF); reg_read(4'd1, v); check("R11 base high 7 bits", v, 16'h007F);
        reg_write(4'd1, 16'h0000);
        reg_write(4'd7, 16'hF580); reg_read(4'd7, v); check("R11 ctrl", v, 16'h1580);
        reg_write(4'd2, 16'hFFFF); reg_read(4'd2, v); check("R2 length width", v, 16'h0007);
        reg_write(4'd2, 16'h0000);

        // R6 / R7 status composition
        busy_2d = 1'b1; reg_read(4'd8, v); check("R7 busy 2d", v, 16'h0013);
        busy_2d = 1'b0; busy_3d = 1'b1; reg_read(4'd8, v); check("R7 busy 3d", v, 16'h0023);
        busy_3d = 1'b0; busy_isp = 1'b1; reg_read(4'd8, v); check("R7 busy isp", v, 16'h0103);
        busy_isp = 1'b0; reg_read(4'd8, v); check("R6 all idle", v, 16'h0007);

        // R3 high half alone starts nothing
        reg_write(4'd4, 16'h0001);
        repeat (10) @(negedge clk);
        reg_read(4'd8, v); check("R3 idle after high write", v, 16'h0007);
        reg_read(4'd3, v); check("R3 wptr unchanged", v, 16'h0000);

        // R2 mask + R4 even + R10 zero-pair no-op: 0x0805 -> 0x0004 over zero memory
        reg_write(4'd3, 16'h0805);
        reg_read(4'd3, v); check("R2 wptr masked", v, 16'h0004);
        wait_idle();
        reg_read(4'd5, v); check("R10 rptr past no-op", v, 16'h0004);
        wp_model = 4;

        // R4/R9 plain stream
        stage.push_back(16'h1234); stage.push_back(16'hABCD);
        stage.push_back(16'h0001); stage.push_back(16'h0002);
        commit();

        // R10 mixed zero pair and lone halfword, with stalls (R9)
        stall_mode = 1'b1;
        stage.push_back(16'h00FF); stage.push_back(16'h0000);
        stage.push_back(16'h0000); stage.push_back(16'h0000);
        stage.push_back(16'h5555);
        commit();
        reg_read(4'd5, v); check("R10 rptr after odd group", v, 16'(wp_model));

        // R10 lone zero halfword is still emitted
        stage.push_back(16'h0000);
        commit();

        // R2 wrap: push well past the 1 KiB boundary
        for (int k = 0; k < 3; k++) begin
            for (int i = 0; i < 300; i++) stage.push_back(16'((i * 37 + k * 11) & 16'hFFFF) | 16'h0100);
            commit();
        end
        reg_read(4'd5, v); check("R2 rptr after wrap", v, 16'(wp_model));

        // R5 equal pointers: quiet
        repeat (30) @(negedge clk);
        reg_read(4'd8, v); check("R5 idle when equal", v, 16'h0007);
        check("R5 no pending words", 16'(exp_q.size()), 16'h0000);
        check("R8 single outstanding read", 16'(r8_viol), 16'h0000);
        check("R9 stalled word held", 16'(r9_viol), 16'h0000);

        finish_run();
    end

endmodule